// File: doc/BRIEF.md
# Address Translation Cache with Flat Page-Table Walker

This block turns 32-bit virtual addresses into 25-bit physical addresses for 8 KB pages. Recent translations sit in a small fully-associative cache. When a lookup finds no translation, a walker reads one 16-bit entry from a flat page table in main memory. The table is indexed directly by virtual page number and has no tag compare. A valid entry is installed in the cache and then used. An invalid entry is not installed. It is reported as a page fault, and the response carries the disk location held in the entry's low bits.

Stores are tracked per page. The first store to a page whose table entry is still clean writes that entry back with its dirty bit set, and the store is acknowledged only after that write. Any later store to the same page causes no memory traffic. When every cache slot is valid, a fill evicts the least recently used slot. A flush input drops every cached translation in one cycle. Only one request is in flight at a time.

Top module: `tlb_walker`

## Requirements
- R1: A physical address is the 12-bit physical page number in bits 24..13 joined to the unchanged 13-bit page offset in bits 12..0. The virtual page number is virtual address bits 31..13.
- R2: On a miss the block issues exactly one memory read at `table_base + 2*vpn`. In the 16-bit table entry, bit 15 is valid, bit 14 is dirty, and bits 11..0 hold the physical page number when the entry is valid.
- R3: A load that hits, or a store that hits a page already dirty, makes no memory access. Its response appears in the cycle after the request is accepted.
- R4: An entry with bit 15 clear yields a response with `rsp_fault`=1 and `rsp_disk` equal to entry bits 13..0. No translation is installed, so a repeat of the same access walks the table again.
- R5: A store to a page whose entry has bit 14 clear, on a hit or on a miss, writes the entry back with bits 15 and 14 set before the response. Further stores to that page cause no write.
- R6: A store that misses to an entry whose bit 14 is already set produces one table read and no write.
- R7: When all slots are valid, a fill replaces the slot whose last use is oldest. Slots used more recently stay resident.
- R8: A one-cycle `flush` pulse invalidates every cached translation, so the next access to any page walks the table.
- R9: `req_ready` is low whenever a table access is in progress, so at most one request is outstanding.
- R10: While `mem_req` is high and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| table_base | input | 25 | Byte address of page-table entry 0 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 25 | Translated physical address |
| rsp_fault | output | 1 | Page fault: the entry is not resident |
| rsp_disk | output | 14 | Disk location from a faulting entry |
| mem_req | output | 1 | Page-table memory access request |
| mem_we | output | 1 | 1 = write entry back, 0 = read entry |
| mem_addr | output | 25 | Byte address of the entry |
| mem_wdata | output | 16 | Entry value to write |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 16 | Entry read, valid with `mem_ack` |

## Verification
The bench builds the block with `ENTRIES`=4 and keeps the address widths and entry format at their defaults. Four slots are filled after a handful of requests, so eviction order under LRU replacement becomes reachable within a short scenario. The same sequence also covers fault entries, clean and pre-dirtied pages, and a flush. The memory model answers after several cycles, which exposes the ready-low window during a walk and the hold rule on the memory request.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 25,
  parameter int OFF_W   = 13,
  parameter int PTE_W   = 16,
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PA_W-1:0]   table_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [PTE_W-3:0]  rsp_disk,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [PTE_W-1:0]  mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int LOC_W = PTE_W - 2;
  localparam int AGE_W = $clog2(ENTRIES);
  localparam int VB    = PTE_W - 1;
  localparam int DB    = PTE_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WB} st_t;
  st_t state;

  logic [VPN_W-1:0] tag [ENTRIES];
  logic [PPN_W-1:0] ppn [ENTRIES];
  logic [AGE_W-1:0] age [ENTRIES];
  logic [ENTRIES-1:0] vld, drt, hit_vec;

  logic [VPN_W-1:0] q_vpn;
  logic [OFF_W-1:0] q_off;
  logic             q_we;
  logic [PTE_W-1:0] q_pte;

  logic [VPN_W-1:0] lk_vpn;
  logic [AGE_W-1:0] hit_idx, inv_idx, lru_idx, vic_idx, t_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic             hit, hit_drt, any_inv, acc, install, touch;

  assign req_ready = (state == S_IDLE);
  assign acc       = req_valid && req_ready;
  assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = table_base + PA_W'({q_vpn, 1'b0});
  assign mem_wdata = q_pte;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tag[g] == lk_vpn);
  end

  always_comb begin
    hit_idx = '0; hit_ppn = '0; hit_drt = 1'b0;
    inv_idx = '0; lru_idx = '0; any_inv = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_idx = AGE_W'(i); hit_ppn = ppn[i]; hit_drt = drt[i];
      end
      if (!vld[i]) begin
        inv_idx = AGE_W'(i); any_inv = 1'b1;
      end
      if (age[i] == AGE_W'(ENTRIES - 1)) lru_idx = AGE_W'(i);
    end
  end

  assign hit     = |hit_vec;
  assign vic_idx = any_inv ? inv_idx : lru_idx;
  assign install = (state == S_RD) && mem_ack && mem_rdata[VB];
  assign touch   = (acc && hit) || install;
  assign t_idx   = (state == S_IDLE) ? hit_idx : vic_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= AGE_W'(i);
    end else begin
      if (touch)
        for (int i = 0; i < ENTRIES; i++)
          if (AGE_W'(i) == t_idx) age[i] <= '0;
          else if (age[i] < age[t_idx]) age[i] <= age[i] + 1'b1;
      if (acc && hit && req_write) drt[hit_idx] <= 1'b1;
      if (install) begin
        drt[vic_idx] <= mem_rdata[DB] | q_we;
        vld[vic_idx] <= 1'b1;
      end
      if (flush) vld <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag[vic_idx] <= q_vpn;
      ppn[vic_idx] <= mem_rdata[PPN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_disk  <= '0;
      q_vpn <= '0; q_off <= '0; q_we <= 1'b0; q_pte <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (acc) begin
          q_vpn <= lk_vpn;
          q_off <= req_vaddr[OFF_W-1:0];
          q_we  <= req_write;
          if (!hit) state <= S_RD;
          else if (req_write && !hit_drt) begin
            q_pte <= {2'b11, {(LOC_W-PPN_W){1'b0}}, hit_ppn};
            state <= S_WB;
          end else begin
            rsp_valid <= 1'b1; rsp_fault <= 1'b0; rsp_disk <= '0;
            rsp_paddr <= {hit_ppn, req_vaddr[OFF_W-1:0]};
          end
        end
        S_RD: if (mem_ack) begin
          if (!mem_rdata[VB]) begin
            rsp_valid <= 1'b1; rsp_fault <= 1'b1;
            rsp_disk  <= mem_rdata[LOC_W-1:0];
            state     <= S_IDLE;
          end else if (q_we && !mem_rdata[DB]) begin
            q_pte     <= mem_rdata | (PTE_W'(1) << DB);
            state     <= S_WB;
          end else begin
            rsp_valid <= 1'b1; rsp_fault <= 1'b0; rsp_disk <= '0;
            rsp_paddr <= {mem_rdata[PPN_W-1:0], q_off};
            state     <= S_IDLE;
          end
        end
        S_WB: if (mem_ack) begin
          rsp_valid <= 1'b1; rsp_fault <= 1'b0; rsp_disk <= '0;
          rsp_paddr <= {q_pte[PPN_W-1:0], q_off};
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_hit_answers_without_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit && (!req_write || hit_drt)) |=> (rsp_valid && !rsp_fault && !mem_req));

  a_r4_fault_installs_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !$past(flush)) |-> (vld == $past(vld)));

  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r5_writeback_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[VB] && mem_wdata[DB]));
endmodule

// File: tb/sim_tlb_walker.sv
module sim_tlb_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [24:0] BASE = 25'h100000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_req, mem_we;
  logic [24:0] rsp_paddr, mem_addr;
  logic [13:0] rsp_disk;
  logic [15:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_walker #(.ENTRIES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .table_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_disk(rsp_disk),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int checks = 0, fails = 0, reads = 0, writes = 0;
  int hold_viol = 0, ready_viol = 0, wait_cnt = 0;
  logic [24:0] hold_addr, last_rd_addr;
  logic [15:0] table_mem [int];
  logic [39:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  function automatic logic [15:0] dflt(logic [18:0] vpn);
    logic [18:0] p;
    p = vpn * 7 + 3;
    if (vpn[3:0] == 4'hF) return {2'b00, vpn[13:0] ^ 14'h2A5};
    return {1'b1, vpn[4], 2'b00, p[11:0]};
  endfunction

  function automatic logic [15:0] word_at(logic [24:0] a);
    logic [24:0] d;
    if (table_mem.exists(int'(a))) return table_mem[int'(a)];
    d = (a - BASE) >> 1;
    return dflt(d[18:0]);
  endfunction

  function automatic logic [24:0] pte_addr(logic [18:0] vpn);
    return BASE + {5'd0, vpn, 1'b0};
  endfunction

  task automatic check(bit ok, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (req_ready) ready_viol++;
      if (wait_cnt == 0) hold_addr = mem_addr;
      else if (mem_addr != hold_addr) hold_viol++;
      if (wait_cnt == 2) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          table_mem[int'(mem_addr)] = mem_wdata;
          writes++;
        end else begin
          mem_rdata = word_at(mem_addr);
          last_rd_addr = mem_addr;
          reads++;
        end
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R1 unexpected response", {14'd0, rsp_fault, rsp_paddr}, 40'd0);
      else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[39]) check(rsp_fault && rsp_disk == e[38:25], t, {rsp_fault, rsp_disk, 25'd0}, {e[39:25], 25'd0});
        else check(!rsp_fault && rsp_paddr == e[24:0], t, {rsp_fault, 14'd0, rsp_paddr}, e);
      end
    end
  end

  task automatic send(logic [18:0] vpn, logic [12:0] off, bit we, int drd, int dwr, bit exp_hit, string t);
    logic [15:0] p;
    int r0, w0, lat;
    p = word_at(pte_addr(vpn));
    if (!p[15]) exp_q.push_back({1'b1, p[13:0], 25'd0});
    else exp_q.push_back({1'b0, 14'd0, p[11:0], off});
    tag_q.push_back(t);
    r0 = reads; w0 = writes;
    req_vaddr = {vpn, off}; req_write = we; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    check(reads - r0 == drd, {t, " table reads"}, 40'(reads - r0), 40'(drd));
    check(writes - w0 == dwr, {t, " table writes"}, 40'(writes - w0), 40'(dwr));
    if (exp_hit) check(lat == 1, {t, " R3 hit latency"}, 40'(lat), 40'd1);
    if (drd > 0) check(last_rd_addr == pte_addr(vpn), {t, " R2 entry address"}, 40'(last_rd_addr), 40'(pte_addr(vpn)));
  endtask

  localparam logic [18:0] VA = 19'h00021, VB = 19'h00102, VC = 19'h01003;
  localparam logic [18:0] VD = 19'h00034, VE = 19'h20005, VF = 19'h0004F;

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "reset state", {37'd0, req_ready, rsp_valid, mem_req}, 40'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "reset release", {37'd0, req_ready, rsp_valid, mem_req}, 40'd4);

    send(VA, 13'h1ABC, 0, 1, 0, 0, "R2 miss load A");
    send(VA, 13'h0007, 0, 0, 0, 1, "R3 hit load A");
    send(VA, 13'h1FFF, 0, 0, 0, 1, "R1 offset max A");
    send(VF, 13'h0010, 0, 1, 0, 0, "R4 fault");
    send(VF, 13'h0010, 0, 1, 0, 0, "R4 fault repeat walks");
    send(VB, 13'h0123, 1, 1, 1, 0, "R5 store miss clean B");
    check(word_at(pte_addr(VB))[15:14] == 2'b11, "R5 B entry dirty in table",
          40'(word_at(pte_addr(VB))), 40'hC000);
    send(VB, 13'h0456, 1, 0, 0, 1, "R5 second store B");
    send(VA, 13'h0000, 1, 0, 1, 0, "R5 store hit clean A");
    send(VA, 13'h0001, 1, 0, 0, 1, "R5 repeat store A");
    send(VD, 13'h0abc, 1, 1, 0, 0, "R6 store pre-dirty D");

    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    send(VA, 13'h0002, 0, 1, 0, 0, "R8 after flush A");
    send(VB, 13'h0003, 0, 1, 0, 0, "R7 fill B");
    send(VC, 13'h0004, 0, 1, 0, 0, "R7 fill C");
    send(VD, 13'h0005, 0, 1, 0, 0, "R7 fill D");
    send(VA, 13'h0006, 0, 0, 0, 1, "R7 touch A");
    send(VE, 13'h0007, 0, 1, 0, 0, "R7 fill E evicts B");
    send(VA, 13'h0008, 0, 0, 0, 1, "R7 A kept");
    send(VC, 13'h0009, 0, 0, 0, 1, "R7 C kept");
    send(VD, 13'h000A, 0, 0, 0, 1, "R7 D kept");
    send(VB, 13'h000B, 0, 1, 0, 0, "R7 B was evicted");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all responses seen", 40'(exp_q.size()), 40'd0);
    check(ready_viol == 0, "R9 ready low during walk", 40'(ready_viol), 40'd0);
    check(hold_viol == 0, "R10 request held", 40'(hold_viol), 40'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule